// File: doc/BRIEF.md
# Two-Channel Double-Buffered Converter Control Registers

This block keeps the digital control state of a two-channel, span-programmable converter. Each channel has two stages. A staging register holds a code and a span that have been written but not yet applied. An active register drives the converter. Commands arrive as parallel fields inside a frame marked by an active-low frame strobe. A command takes effect when the strobe returns high. The opcode can write the staging registers, copy staging into active, or do both at once. The address picks one channel, both channels, or none.

A level-sensitive clear input zeroes the active codes and keeps the staged values, so a later update restores the earlier outputs. A clear that arrives while a frame is open cancels that command. A write cancelled this way marks the addressed staging registers as suspect, and a readback port lets software see this. A synchronous active-low load input copies staging into active for every channel. A manual-span mode takes the span from strap inputs on every update. An active-low integrity flag reports a possible loss of state. All inputs are sampled on the rising clock edge.

Top module: `dac_ctrl_regs`

## Requirements
- R1: While `rstN` is low and after it is released, every staging and active code is 0, every span is 4'b0000, `rdBad` is 0 and `integFlagN` is 0.
- R2: Opcode 2'b01 (write) loads `cmdCode`/`cmdSpan` into the staging registers of the addressed channels and leaves the active registers unchanged; `rdCode`/`rdSpan` show the staging register selected by `rdSel`.
- R3: Opcode 2'b10 (update) copies the staging code and span of each addressed channel into its active register.
- R4: Opcode 2'b11 writes the new code and span into staging and active registers of the addressed channels in the same cycle.
- R5: Address 2'b00 selects channel 0, 2'b01 channel 1, 2'b11 both channels at once; 2'b10 selects no channel.
- R6: A command uses the field values sampled in the last cycle that `frameN` was low and takes effect on the first rising edge at which `frameN` is sampled high; opcode 2'b00 changes nothing.
- R7: While `clrN` is sampled low every active code is forced to 0 and staging registers are kept; a later update restores the staged values to the outputs.
- R8: If `clrN` is sampled low while a frame is open (including the edge that closes it), the command performs nothing; if it was a write, `rdBad` of each addressed channel becomes 1 until a successful write to that channel.
- R9: While `ldacN` is sampled low and `clrN` high, every channel's staging code and span are copied into its active register; while `clrN` is low, `ldacN` has no effect.
- R10: While `manSpanEn` is 1, every update (by command or by `ldacN`) loads `spanPins` into the active span of the channels it touches, together with the code.
- R11: `integFlagN` goes low one cycle after `clrN` is sampled low or `brownout` is sampled high, and goes high only after a valid command with an update opcode (2'b10 or 2'b11); writes and `ldacN` do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| frameN | input | 1 | Active-low command frame strobe |
| cmdOp | input | 2 | Opcode: 00 none, 01 write, 10 update, 11 write and update |
| cmdAddr | input | 2 | Channel address; 2'b11 selects both channels |
| cmdCode | input | 16 | Code for write commands |
| cmdSpan | input | 4 | Span for write commands |
| ldacN | input | 1 | Active-low synchronous load of all channels |
| clrN | input | 1 | Active-low clear of the active codes |
| brownout | input | 1 | Supply-low indication, high when low supply |
| manSpanEn | input | 1 | Manual span mode enable |
| spanPins | input | 4 | Strapped span used in manual mode |
| rdSel | input | 1 | Channel chosen for readback |
| rdCode | output | 16 | Staging code of the selected channel |
| rdSpan | output | 4 | Staging span of the selected channel |
| rdBad | output | 1 | Selected staging register is suspect after an aborted write |
| dacCode | output | 32 | Active codes, channel 0 in the low half |
| dacSpan | output | 8 | Active spans, channel 0 in the low nibble |
| integFlagN | output | 1 | Active-low data integrity flag |

## Verification
A command opens at one falling edge and closes when `frameN` is raised at the next. Its result shows after the first rising edge that sees `frameN` high, so the bench samples at the falling edge after that one. It also checks at the intermediate falling edge that the active registers have not yet moved. Clear, brownout and load pulses last one clock, and their effects are due after that single rising edge. The readback outputs are combinational and are read a fraction of a nanosecond after `rdSel` changes, well before the next rising edge. A sweep of every opcode against every address compares all outputs with an arithmetic model after each frame.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int CH_N   = 2;
  localparam int ADDR_W = $clog2(CH_N) + 1;
  localparam int SEL_W  = (CH_N > 1) ? $clog2(CH_N) : 1;

  typedef enum logic [1:0] {
    OP_NOP    = 2'b00,
    OP_WRITE  = 2'b01,
    OP_UPDATE = 2'b10,
    OP_WRUPD  = 2'b11
  } cmd_op_e;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic            capture;
    logic            clearAct;
    logic            useManSpan;
    logic [CH_N-1:0] wrIn;
    logic [CH_N-1:0] upd;
    logic [CH_N-1:0] markBad;
  } ctrl_strobe_t;
endpackage

// File: rtl/dac_ctrl_seq.sv
module dac_ctrl_seq
  import dac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              ldacN,
  input  logic              clrN,
  input  logic              brownout,
  input  logic              manSpanEn,
  output ctrl_strobe_t      strobe,
  output logic              integFlagN
);
  logic              frameOpenQ;
  logic              abortQ;
  cmd_op_e           capOp;
  logic [ADDR_W-1:0] capAddr;
  logic [CH_N-1:0]   selMask;
  logic              frameEnd;
  logic              execute;
  logic              opWrites;
  logic              opUpdates;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameOpenQ <= 1'b0;
      abortQ     <= 1'b0;
      capOp      <= OP_NOP;
      capAddr    <= '0;
      integFlagN <= 1'b0;
    end else begin
      frameOpenQ <= !frameN;
      if (!frameN) begin
        capOp   <= cmd_op_e'(cmdOp);
        capAddr <= cmdAddr;
      end
      // a clear seen anywhere in an open frame cancels its command
      if (!clrN && (!frameN || frameOpenQ)) abortQ <= 1'b1;
      else if (!frameN && !frameOpenQ)      abortQ <= 1'b0;
      if (!clrN || brownout)                integFlagN <= 1'b0;
      else if (execute && opUpdates)        integFlagN <= 1'b1;
    end
  end

  always_comb begin
    for (int c = 0; c < CH_N; c++) begin
      selMask[c] = (capAddr == '1) || (capAddr == ADDR_W'(c));
    end
  end

  assign opWrites  = (capOp == OP_WRITE)  || (capOp == OP_WRUPD);
  assign opUpdates = (capOp == OP_UPDATE) || (capOp == OP_WRUPD);
  assign frameEnd  = frameOpenQ && frameN;
  assign execute   = frameEnd && clrN && !abortQ && (capOp != OP_NOP);

  always_comb begin
    strobe            = '0;
    strobe.capture    = !frameN;
    strobe.clearAct   = !clrN;
    strobe.useManSpan = manSpanEn;
    strobe.wrIn       = (execute && opWrites) ? selMask : '0;
    strobe.upd        = ((execute && opUpdates) ? selMask : '0)
                      | ((!ldacN && clrN) ? {CH_N{1'b1}} : '0);
    strobe.markBad    = (frameEnd && (abortQ || !clrN) && opWrites) ? selMask : '0;
  end
endmodule

// File: rtl/dac_ctrl_dp.sv
module dac_ctrl_dp
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int SPAN_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_strobe_t             strobe,
  input  logic [CODE_W-1:0]        cmdCode,
  input  logic [SPAN_W-1:0]        cmdSpan,
  input  logic [SPAN_W-1:0]        spanPins,
  input  logic [SEL_W-1:0]         rdSel,
  output logic [CODE_W-1:0]        rdCode,
  output logic [SPAN_W-1:0]        rdSpan,
  output logic                     rdBad,
  output logic [CH_N*CODE_W-1:0]   dacCode,
  output logic [CH_N*SPAN_W-1:0]   dacSpan
);
  logic [CODE_W-1:0] capCode;
  logic [SPAN_W-1:0] capSpan;
  logic [CODE_W-1:0] inCode  [CH_N];
  logic [SPAN_W-1:0] inSpan  [CH_N];
  logic              inBad   [CH_N];
  logic [CODE_W-1:0] actCode [CH_N];
  logic [SPAN_W-1:0] actSpan [CH_N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capCode <= '0;
      capSpan <= '0;
    end else if (strobe.capture) begin
      capCode <= cmdCode;
      capSpan <= cmdSpan;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [CODE_W-1:0] srcCode;
    logic [SPAN_W-1:0] srcSpan;
    assign srcCode = strobe.wrIn[c] ? capCode : inCode[c];
    assign srcSpan = strobe.useManSpan ? spanPins
                   : (strobe.wrIn[c] ? capSpan : inSpan[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inCode[c]  <= '0;
        inSpan[c]  <= '0;
        inBad[c]   <= 1'b0;
        actCode[c] <= '0;
        actSpan[c] <= '0;
      end else begin
        if (strobe.wrIn[c]) begin
          inCode[c] <= capCode;
          inSpan[c] <= capSpan;
          inBad[c]  <= 1'b0;
        end else if (strobe.markBad[c]) begin
          inBad[c]  <= 1'b1;
        end
        if (strobe.clearAct) begin
          actCode[c] <= '0;
        end else if (strobe.upd[c]) begin
          actCode[c] <= srcCode;
          actSpan[c] <= srcSpan;
        end
      end
    end

    assign dacCode[c*CODE_W +: CODE_W] = actCode[c];
    assign dacSpan[c*SPAN_W +: SPAN_W] = actSpan[c];
  end

  assign rdCode = inCode[rdSel];
  assign rdSpan = inSpan[rdSel];
  assign rdBad  = inBad[rdSel];
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int SPAN_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameN,
  input  logic [1:0]             cmdOp,
  input  logic [ADDR_W-1:0]      cmdAddr,
  input  logic [CODE_W-1:0]      cmdCode,
  input  logic [SPAN_W-1:0]      cmdSpan,
  input  logic                   ldacN,
  input  logic                   clrN,
  input  logic                   brownout,
  input  logic                   manSpanEn,
  input  logic [SPAN_W-1:0]      spanPins,
  input  logic [SEL_W-1:0]       rdSel,
  output logic [CODE_W-1:0]      rdCode,
  output logic [SPAN_W-1:0]      rdSpan,
  output logic                   rdBad,
  output logic [CH_N*CODE_W-1:0] dacCode,
  output logic [CH_N*SPAN_W-1:0] dacSpan,
  output logic                   integFlagN
);
  ctrl_strobe_t strobe;

  dac_ctrl_seq u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .frameN     (frameN),
    .cmdOp      (cmdOp),
    .cmdAddr    (cmdAddr),
    .ldacN      (ldacN),
    .clrN       (clrN),
    .brownout   (brownout),
    .manSpanEn  (manSpanEn),
    .strobe     (strobe),
    .integFlagN (integFlagN)
  );

  dac_ctrl_dp #(.CODE_W(CODE_W), .SPAN_W(SPAN_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdCode  (cmdCode),
    .cmdSpan  (cmdSpan),
    .spanPins (spanPins),
    .rdSel    (rdSel),
    .rdCode   (rdCode),
    .rdSpan   (rdSpan),
    .rdBad    (rdBad),
    .dacCode  (dacCode),
    .dacSpan  (dacSpan)
  );
endmodule

// File: rtl/dac_ctrl_regs_chk.sv
module dac_ctrl_regs_chk
  import dac_ctrl_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int SPAN_W = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   frameN,
  input logic                   ldacN,
  input logic                   clrN,
  input logic                   brownout,
  input logic                   manSpanEn,
  input logic [SPAN_W-1:0]      spanPins,
  input logic [SEL_W-1:0]       rdSel,
  input logic [CODE_W-1:0]      rdCode,
  input logic [CH_N*CODE_W-1:0] dacCode,
  input logic [CH_N*SPAN_W-1:0] dacSpan,
  input logic                   integFlagN
);
  // R7: a sampled clear leaves every active code at zero
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> (dacCode == '0));

  // R11: clear or brownout pulls the integrity flag low
  a_r11_flag_low: assert property (@(posedge clk) disable iff (!rstN)
    (!clrN || brownout) |=> !integFlagN);

  // R11: the flag only rises right after a frame closes
  a_r11_flag_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(integFlagN) |-> ($past(frameN) && !$past(frameN, 2)));

  // R2: with no frame closing, staging contents seen on readback hold
  a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rstN)
    (frameN && $past(frameN)) |=> ($stable(rdSel) -> $stable(rdCode)));

  // R10: a load in manual mode applies the strapped span everywhere
  a_r10_manual_span: assert property (@(posedge clk) disable iff (!rstN)
    (manSpanEn && !ldacN && clrN) |=> (dacSpan == {CH_N{$past(spanPins)}}));
endmodule

bind dac_ctrl_regs dac_ctrl_regs_chk #(.CODE_W(CODE_W), .SPAN_W(SPAN_W)) u_chk (.*);

// File: tb/dac_ctrl_regs_tb.sv
`timescale 1ns/100ps
module dac_ctrl_regs_tb;
  import dac_ctrl_pkg::*;
  localparam int CW = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0, frameN = 1'b1, ldacN = 1'b1, clrN = 1'b1;
  logic brownout = 1'b0, manSpanEn = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [CW-1:0] cmdCode = '0;
  logic [SW-1:0] cmdSpan = '0, spanPins = '0;
  logic [SEL_W-1:0] rdSel = '0;
  logic [CW-1:0] rdCode;
  logic [SW-1:0] rdSpan;
  logic rdBad, integFlagN;
  logic [CH_N*CW-1:0] dacCode;
  logic [CH_N*SW-1:0] dacSpan;

  int nChecks = 0, nErrors = 0;
  bit done = 1'b0;

  logic [CW-1:0] mIn [CH_N], mDac [CH_N];
  logic [SW-1:0] mInSpan [CH_N], mDacSpan [CH_N];
  logic mBad [CH_N];
  logic mFlag;

  always #2 clk = ~clk;

  dac_ctrl_regs #(.CODE_W(CW), .SPAN_W(SW)) u_dut (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    for (int c = 0; c < CH_N; c++) begin
      check(req, "dacCode", 32'(dacCode[c*CW +: CW]), 32'(mDac[c]));
      check(req, "dacSpan", 32'(dacSpan[c*SW +: SW]), 32'(mDacSpan[c]));
      rdSel = SEL_W'(c);
      #0.2;
      check(req, "rdCode", 32'(rdCode), 32'(mIn[c]));
      check(req, "rdSpan", 32'(rdSpan), 32'(mInSpan[c]));
      check(req, "rdBad", 32'(rdBad), 32'(mBad[c]));
    end
    check(req, "integFlagN", 32'(integFlagN), 32'(mFlag));
  endtask

  function automatic logic [CH_N-1:0] maskOf(logic [1:0] a);
    if (a == 2'b11) return '1;
    if (a < 2) return CH_N'(1) << a;
    return '0;
  endfunction

  task automatic modelLoadAll();
    for (int c = 0; c < CH_N; c++) begin
      mDac[c] = mIn[c];
      mDacSpan[c] = manSpanEn ? spanPins : mInSpan[c];
    end
  endtask

  task automatic frame(logic [1:0] op, logic [1:0] a, logic [CW-1:0] code, logic [SW-1:0] span);
    logic [CH_N-1:0] m;
    @(negedge clk);
    frameN = 1'b0; cmdOp = op; cmdAddr = a; cmdCode = code; cmdSpan = span;
    @(negedge clk);
    frameN = 1'b1;
    @(negedge clk);
    m = maskOf(a);
    if (op != 2'b00) begin
      for (int c = 0; c < CH_N; c++) begin
        if (m[c]) begin
          if (op[0]) begin mIn[c] = code; mInSpan[c] = span; mBad[c] = 1'b0; end
          if (op[1]) begin mDac[c] = mIn[c]; mDacSpan[c] = manSpanEn ? spanPins : mInSpan[c]; end
        end
      end
      if (op[1]) mFlag = 1'b1;
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < CH_N; c++) begin
      mIn[c] = '0; mDac[c] = '0; mInSpan[c] = '0; mDacSpan[c] = '0; mBad[c] = 1'b0;
    end
    mFlag = 1'b0;
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R2 R3 R4 R5 R6: every opcode against every address
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < 4; a++) begin
        frame(2'(op), 2'(a), CW'(16'h1000 * op + 16'h0100 * a + 16'h0011), SW'(op * 4 + a));
        if (a == 2 || a == 3) checkAll("R5");
        else if (op == 0) checkAll("R6");
        else if (op == 1) checkAll("R2");
        else if (op == 2) checkAll("R3");
        else checkAll("R4");
      end
    end

    // R6: nothing moves before the frame closes
    @(negedge clk);
    frameN = 1'b0; cmdOp = 2'b11; cmdAddr = 2'b00; cmdCode = 16'hA5A5; cmdSpan = 4'h6;
    @(negedge clk);
    frameN = 1'b1;
    check("R6", "dacCode before close", 32'(dacCode[CW-1:0]), 32'(mDac[0]));
    @(negedge clk);
    mIn[0] = 16'hA5A5; mInSpan[0] = 4'h6; mDac[0] = 16'hA5A5; mDacSpan[0] = 4'h6;
    checkAll("R6");

    // R7: clear zeroes active codes, update restores them
    @(negedge clk); clrN = 1'b0;
    @(negedge clk); clrN = 1'b1;
    for (int c = 0; c < CH_N; c++) mDac[c] = '0;
    mFlag = 1'b0;
    checkAll("R7");
    frame(2'b10, 2'b11, 16'h0, 4'h0);
    checkAll("R7");

    // R8: clear inside a write frame aborts it and marks channel 0 suspect
    @(negedge clk);
    frameN = 1'b0; cmdOp = 2'b01; cmdAddr = 2'b00; cmdCode = 16'hBEEF; cmdSpan = 4'hF;
    @(negedge clk); clrN = 1'b0;
    @(negedge clk); clrN = 1'b1; frameN = 1'b1;
    @(negedge clk);
    for (int c = 0; c < CH_N; c++) mDac[c] = '0;
    mFlag = 1'b0; mBad[0] = 1'b1;
    checkAll("R8");
    frame(2'b01, 2'b00, 16'h1234, 4'h3);
    checkAll("R8");

    // R9: load pin copies every channel, ignored under clear
    frame(2'b01, 2'b11, 16'h4321, 4'h9);
    @(negedge clk); ldacN = 1'b0;
    @(negedge clk); ldacN = 1'b1;
    modelLoadAll();
    checkAll("R9");
    frame(2'b01, 2'b01, 16'h7777, 4'h2);
    @(negedge clk); ldacN = 1'b0; clrN = 1'b0;
    @(negedge clk); ldacN = 1'b1; clrN = 1'b1;
    for (int c = 0; c < CH_N; c++) mDac[c] = '0;
    mFlag = 1'b0;
    checkAll("R9");

    // R10: manual span mode uses strapped span
    manSpanEn = 1'b1; spanPins = 4'hA;
    frame(2'b10, 2'b11, 16'h0, 4'h0);
    checkAll("R10");
    spanPins = 4'h5;
    @(negedge clk); ldacN = 1'b0;
    @(negedge clk); ldacN = 1'b1;
    modelLoadAll();
    checkAll("R10");
    manSpanEn = 1'b0;

    // R11: brownout drops the flag, only an update raises it
    @(negedge clk); brownout = 1'b1;
    @(negedge clk); brownout = 1'b0;
    mFlag = 1'b0;
    checkAll("R11");
    frame(2'b01, 2'b01, 16'h2468, 4'h1);
    checkAll("R11");
    frame(2'b10, 2'b01, 16'h0, 4'h0);
    checkAll("R11");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule